// File: doc/BRIEF.md
# GPIO Interrupt Detector

This block sits between a bank of general-purpose input pins and an interrupt controller. Every pin is brought into the clock domain through a two-stage synchroniser. A per-pin condition detector then watches for the trigger selected for that pin: a rising edge, a falling edge, a high level or a low level. When the chosen condition is seen, the detector latches a pending flag. The flag stays set until software clears it by writing a one to its bit.

A per-pin enable mask decides which pending flags may reach the single request line toward the interrupt controller. A pending flag is recorded whether or not its pin is enabled, so an event that arrives while the pin is masked raises the request as soon as the mask bit is set. In the two level modes the flag keeps setting again while the pin remains at its trigger level, so clearing it has no lasting effect until the source lets go. In the two edge modes a clear is final until a new edge arrives.

Software reaches the block through a small register port: a write strobe, a two-bit address and a data word. Reads are combinational from the address.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset the pending, mask and trigger-mode registers are all zero (every pin is in rising-edge mode), and `irq_o` is low.
- R2: A pin change sampled at clock edge k reaches the detector after two synchroniser stages. The resulting pending bit is visible after edge k+2 and not earlier.
- R3: Trigger code 2'b00 (rising edge): a high pulse lasting only one clock sets the pending bit. The bit stays set after the pin returns low, until it is cleared.
- R4: Trigger code 2'b01 (falling edge): a high-to-low transition sets the pending bit. A rising transition does not.
- R5: Trigger code 2'b10 (high level): whenever the synchronised pin is high, the pending bit is set on the next edge. A clear while the pin stays high therefore leaves the bit set.
- R6: Trigger code 2'b11 (low level): whenever the synchronised pin is low, the pending bit is set on the next edge. This includes the edge after the mode is selected.
- R7: In an edge mode, clearing the pending bit while the pin stays at its new level leaves the bit clear.
- R8: When a trigger and a write-one-to-clear of the same bit fall in the same cycle, the bit stays set.
- R9: A write to address 2 clears exactly the pending bits whose data bit is 1. Bits written with 0 are unchanged. Pending bits never drop without such a write.
- R10: `irq_o` is high exactly when some pin has both its pending bit and its mask bit set. A bit that is pending while masked raises `irq_o` in the cycle after its mask bit is written to 1.
- R11: Register map. Address 0 holds the trigger modes, pin i in bits [2i+1:2i], read/write. Address 1 holds the mask, pin i in bit i, read/write. Address 2 holds the pending flags, pin i in bit i; reads return the flags and writes are write-one-to-clear. Address 3 reads zero. Bits above the defined fields read zero, and writes to them are dropped.
- R12: After a clear in an edge mode, a fresh occurrence of the same edge sets the pending bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_i | input | NPIN | Asynchronous input pins |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for reads and writes |
| wdata | input | DW | Register write data |
| rdata | output | DW | Register read data, combinational from `addr` |
| irq_o | output | 1 | Request toward the interrupt controller |

## Verification
The assertions assume that the pins carry no value that the synchroniser would have to resolve within one stage. They also assume that register writes are single-cycle strobes whose address and data are stable around the clock edge, and that the pins sit low while reset is held, so that no edge appears at reset release. The stimulus changes pins and register-port inputs one nanosecond after a rising edge and keeps every pin low through reset. Each pin is held long enough to pass through both synchroniser stages before the next change. One write is deliberately timed to coincide with the cycle in which an edge is latched, to exercise the set-over-clear rule.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
// gpio_irq_pkg
// Shared encodings for the GPIO interrupt detector: trigger codes per pin
// and the register addresses of the software port.
// Assumes: two-bit trigger field per pin, two-bit register address.
package gpio_irq_pkg;

    typedef enum logic [1:0] {
        TRIG_RISE = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_HIGH = 2'b10,
        TRIG_LOW  = 2'b11
    } trig_mode_e;

    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] REG_MODE = 2'd0;
    localparam logic [ADDR_W-1:0] REG_MASK = 2'd1;
    localparam logic [ADDR_W-1:0] REG_PEND = 2'd2;

endpackage

// File: rtl/gpio_irq_sync.sv
`timescale 1ns/1ps
// gpio_irq_sync
// Brings every asynchronous pin into the clock domain through two flops.
// Assumes: pins are independent single-bit signals. No multi-bit coherence
// is needed across them.
module gpio_irq_sync #(
    parameter int unsigned NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_i,
    output logic [NPIN-1:0] sync_o
);

    logic [NPIN-1:0] meta_q;
    logic [NPIN-1:0] stab_q;

    // Two-stage capture of the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= pin_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;

endmodule

// File: rtl/gpio_irq_pin.sv
`timescale 1ns/1ps
// gpio_irq_pin
// Condition detector and pending latch for one synchronised pin.
// An edge is found by comparing the current sample with the previous one.
// A level is taken directly from the current sample. When a set and a clear
// arrive in the same cycle, the set takes priority.
// Assumes: sync_i is already in the clock domain.
module gpio_irq_pin
    import gpio_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_i,
    input  logic [1:0] mode_i,
    input  logic       clr_i,
    output logic       pend_o
);

    trig_mode_e mode_c;
    logic       prev_q;
    logic       hit_c;
    logic       pend_q;

    assign mode_c = trig_mode_e'(mode_i);

    // Remember the previous synchronised sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_i;
    end

    // Decide whether the selected trigger condition holds this cycle.
    always_comb begin
        unique case (mode_c)
            TRIG_RISE: hit_c = sync_i & ~prev_q;
            TRIG_FALL: hit_c = ~sync_i & prev_q;
            TRIG_HIGH: hit_c = sync_i;
            TRIG_LOW:  hit_c = ~sync_i;
            default:   hit_c = 1'b0;
        endcase
    end

    // Pending latch: a clear drops the flag, a hit overrides the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q & ~clr_i) | hit_c;
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/gpio_irq_regs.sv
`timescale 1ns/1ps
// gpio_irq_regs
// Software-visible registers: trigger modes, enable mask, and the
// write-one-to-clear strobe for the pending flags. Read data is a
// combinational mux on the address.
// Assumes: 2*NPIN <= DW, and writes are single-cycle strobes.
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPIN = 8,
    parameter int unsigned DW   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [NPIN-1:0]   pend_i,
    output logic [2*NPIN-1:0] mode_o,
    output logic [NPIN-1:0]   mask_o,
    output logic [NPIN-1:0]   clr_o,
    output logic [DW-1:0]     rdata
);

    localparam int unsigned MODE_W = 2 * NPIN;

    logic [MODE_W-1:0] mode_q;
    logic [NPIN-1:0]   mask_q;

    // Store mode and mask writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (addr == REG_MODE) mode_q <= wdata[MODE_W-1:0];
            if (addr == REG_MASK) mask_q <= wdata[NPIN-1:0];
        end
    end

    // One-cycle clear strobe for the pending latches.
    assign clr_o = (wr_en && addr == REG_PEND) ? wdata[NPIN-1:0] : '0;

    // Read mux, zero-extended to the data width.
    always_comb begin
        rdata = '0;
        unique case (addr)
            REG_MODE: rdata[MODE_W-1:0] = mode_q;
            REG_MASK: rdata[NPIN-1:0]   = mask_q;
            REG_PEND: rdata[NPIN-1:0]   = pend_i;
            default:  rdata             = '0;
        endcase
    end

    generate
        if (MODE_W < DW) begin : g_spare
            logic unused_hi;
            assign unused_hi = ^wdata[DW-1:MODE_W];
        end
    endgenerate

    assign mode_o = mode_q;
    assign mask_o = mask_q;

endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
// gpio_irq_detect
// Top of the GPIO interrupt detector: synchroniser, one detector per pin,
// the register block, and the masked OR that drives the request line.
// Assumes: pins held low during reset; 2*NPIN <= DW.
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPIN = 8,
    parameter int unsigned DW   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   pin_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              irq_o
);

    logic [NPIN-1:0]   sync_w;
    logic [NPIN-1:0]   pend_w;
    logic [NPIN-1:0]   mask_w;
    logic [NPIN-1:0]   clr_w;
    logic [2*NPIN-1:0] mode_w;

    gpio_irq_sync #(.NPIN(NPIN)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .sync_o (sync_w)
    );

    gpio_irq_regs #(.NPIN(NPIN), .DW(DW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .pend_i (pend_w),
        .mode_o (mode_w),
        .mask_o (mask_w),
        .clr_o  (clr_w),
        .rdata  (rdata)
    );

    generate
        for (genvar i = 0; i < NPIN; i++) begin : g_pin
            gpio_irq_pin u_pin (
                .clk    (clk),
                .rst_n  (rst_n),
                .sync_i (sync_w[i]),
                .mode_i (mode_w[2*i +: 2]),
                .clr_i  (clr_w[i]),
                .pend_o (pend_w[i])
            );
        end
    endgenerate

    // Request: any pending pin that is enabled.
    assign irq_o = |(pend_w & mask_w);

endmodule

// File: rtl/gpio_irq_chk.sv
`timescale 1ns/1ps
// gpio_irq_chk
// Property checker for gpio_irq_detect, attached by bind.
// Assumes: the bound instance uses the same NPIN.
module gpio_irq_chk
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPIN = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [NPIN-1:0]   wdata_lo,
    input logic              irq_o,
    input logic [NPIN-1:0]   pend,
    input logic [NPIN-1:0]   mask,
    input logic [2*NPIN-1:0] mode,
    input logic [NPIN-1:0]   sync
);

    // R9: without a clear write, no pending bit drops.
    p_pend_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == REG_PEND) |=> ((pend & $past(pend)) == $past(pend)));

    // R9: a clear write drops only the bits it names.
    p_clear_scope_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_PEND) |=> ((($past(pend) & ~$past(wdata_lo)) & ~pend) == '0));

    // R10: a request needs some pending bit.
    p_irq_needs_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend != '0));

    // R10: nothing enabled means no request.
    p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq_o);

    generate
        for (genvar i = 0; i < NPIN; i++) begin : g_pin
            // R5: high level sets the flag on the next edge, clear or not.
            p_high_rearm_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (mode[2*i +: 2] == TRIG_HIGH && sync[i]) |=> pend[i]);
            // R6: low level sets the flag on the next edge.
            p_low_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (mode[2*i +: 2] == TRIG_LOW && !sync[i]) |=> pend[i]);
            // R3: a synchronised rising edge in rising mode is latched.
            p_rise_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (mode[2*i +: 2] == TRIG_RISE && sync[i] && !$past(sync[i])) |=> pend[i]);
            // R4: a synchronised falling edge in falling mode is latched.
            p_fall_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (mode[2*i +: 2] == TRIG_FALL && !sync[i] && $past(sync[i])) |=> pend[i]);
        end
    endgenerate

endmodule

bind gpio_irq_detect gpio_irq_chk #(.NPIN(NPIN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata_lo (wdata[NPIN-1:0]),
    .irq_o    (irq_o),
    .pend     (pend_w),
    .mask     (mask_w),
    .mode     (mode_w),
    .sync     (sync_w)
);

// File: tb/sim_gpio_irq_detect.sv
`timescale 1ns/1ps
// sim_gpio_irq_detect
// Directed stimulus plus a behavioural reference model. The model keeps a
// queue of past pin samples and computes the pending, mask and mode state,
// and it is compared with the outputs on every clock.
module sim_gpio_irq_detect;

    localparam int NPIN = 8;
    localparam int DW   = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NPIN-1:0] pin_i = '0;
    logic            wr_en = 1'b0;
    logic [1:0]      addr = 2'd2;
    logic [DW-1:0]   wdata = '0;
    logic [DW-1:0]   rdata;
    logic            irq_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    gpio_irq_detect #(.NPIN(NPIN), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    // Reference model state.
    logic [NPIN-1:0]   hist[$];
    logic [NPIN-1:0]   m_pend = '0;
    logic [NPIN-1:0]   m_mask = '0;
    logic [2*NPIN-1:0] m_mode = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0; m_mask = '0; m_mode = '0;
            hist = '{'0, '0, '0};
        end else begin
            logic [NPIN-1:0] cur, old, hit, clr;
            int n;
            n   = hist.size();
            cur = hist[n-2];
            old = hist[n-3];
            for (int i = 0; i < NPIN; i++) begin
                case (m_mode[2*i +: 2])
                    2'b00:   hit[i] = cur[i] && !old[i];
                    2'b01:   hit[i] = !cur[i] && old[i];
                    2'b10:   hit[i] = cur[i];
                    default: hit[i] = !cur[i];
                endcase
            end
            clr = (wr_en && addr == 2'd2) ? wdata[NPIN-1:0] : '0;
            m_pend = (m_pend & ~clr) | hit;
            if (wr_en && addr == 2'd0) m_mode = wdata[2*NPIN-1:0];
            if (wr_en && addr == 2'd1) m_mask = wdata[NPIN-1:0];
            hist.push_back(pin_i);
            void'(hist.pop_front());
        end
    end

    function automatic logic [DW-1:0] m_read(input logic [1:0] a);
        case (a)
            2'd0:    return {{(DW-2*NPIN){1'b0}}, m_mode};
            2'd1:    return {{(DW-NPIN){1'b0}}, m_mask};
            2'd2:    return {{(DW-NPIN){1'b0}}, m_pend};
            default: return '0;
        endcase
    endfunction

    // Compare with the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp++;
            if (irq_o !== |(m_pend & m_mask)) begin
                n_bad++;
                $display("FAIL R10 irq_o actual=%0b expected=%0b", irq_o, |(m_pend & m_mask));
            end
            n_cmp++;
            if (rdata !== m_read(addr)) begin
                n_bad++;
                $display("FAIL R11 rdata@%0d actual=%h expected=%h", addr, rdata, m_read(addr));
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        step(); wr_en = 1'b1; addr = a; wdata = d;
        step(); wr_en = 1'b0; addr = 2'd2; wdata = '0;
    endtask

    task automatic look(input logic [DW-1:0] exp, input string tag);
        @(negedge clk);
        n_cmp++;
        if (rdata !== exp) begin
            n_bad++;
            $display("FAIL %s pending actual=%h expected=%h", tag, rdata, exp);
        end
    endtask

    task automatic look_irq(input logic exp, input string tag);
        @(negedge clk);
        n_cmp++;
        if (irq_o !== exp) begin
            n_bad++;
            $display("FAIL %s irq_o actual=%0b expected=%0b", tag, irq_o, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, input logic [DW-1:0] exp, input string tag);
        step(); addr = a;
        look(exp, tag);
        step(); addr = 2'd2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        look(32'h0, "R1");
        look_irq(1'b0, "R1");
        rd(2'd1, 32'h0, "R1");
        rd(2'd0, 32'h0, "R1");

        // R2 and R3: one-cycle pulse on pin 0, rising mode
        pin_i[0] = 1'b1;
        step(); pin_i[0] = 1'b0;
        look(32'h0, "R2");
        look(32'h0, "R2");
        look(32'h1, "R3");
        look_irq(1'b0, "R10");
        wr(2'd1, 32'h1);
        look_irq(1'b1, "R10");

        // R9: writing zero keeps, writing one clears
        wr(2'd2, 32'h0);
        look(32'h1, "R9");
        wr(2'd2, 32'h1);
        look(32'h0, "R9");

        // R7 and R12: held high, clear, then a fresh edge
        pin_i[0] = 1'b1;
        repeat (4) step();
        look(32'h1, "R3");
        wr(2'd2, 32'h1);
        repeat (4) step();
        look(32'h0, "R7");
        pin_i[0] = 1'b0;
        repeat (4) step();
        pin_i[0] = 1'b1;
        repeat (4) step();
        look(32'h1, "R12");
        wr(2'd2, 32'h1);
        look(32'h0, "R12");

        // R4: falling mode on pin 1
        wr(2'd0, 32'h0000_0004);
        pin_i[1] = 1'b1;
        repeat (5) step();
        look(32'h0, "R4");
        pin_i[1] = 1'b0;
        repeat (4) step();
        look(32'h2, "R4");
        wr(2'd2, 32'h2);
        look(32'h0, "R4");

        // R5: high level on pin 2 re-sets after clear
        wr(2'd0, 32'h0000_0024);
        pin_i[2] = 1'b1;
        repeat (4) step();
        look(32'h4, "R5");
        wr(2'd2, 32'h4);
        look(32'h4, "R5");
        pin_i[2] = 1'b0;
        repeat (4) step();
        wr(2'd2, 32'h4);
        repeat (2) step();
        look(32'h0, "R5");

        // R6: low level on pin 3 sets right after selection
        wr(2'd0, 32'h0000_00E4);
        look(32'h0, "R6");
        look(32'h8, "R6");
        pin_i[3] = 1'b1;
        repeat (4) step();
        wr(2'd2, 32'h8);
        look(32'h0, "R6");

        // R8: clear lands in the same cycle as the edge on pin 4
        pin_i[4] = 1'b1;
        step();
        wr(2'd2, 32'h10);
        look(32'h10, "R8");
        look_irq(1'b0, "R10");
        wr(2'd1, 32'h10);
        look_irq(1'b1, "R10");
        wr(2'd2, 32'h10);
        look_irq(1'b0, "R10");

        // R11: register map readback and dropped upper bits
        rd(2'd0, 32'h0000_00E4, "R11");
        rd(2'd1, 32'h0000_0010, "R11");
        rd(2'd3, 32'h0, "R11");
        wr(2'd0, 32'hFFFF_0000);
        rd(2'd0, 32'h0, "R11");
        wr(2'd1, 32'hFFFF_FF00);
        rd(2'd1, 32'h0, "R11");
        repeat (4) step();
        look(32'h0, "R11");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule